// File: doc/BRIEF.md
# Multi-Lane Test Pattern Source

This block drives a deterministic test stream into a multi-lane streaming source interface. Whenever it offers a transfer, every lane carries a 64-bit sample word. Each word holds the lane's own index, a running burst number and a running word number. A receiver can then check ordering, burst boundaries and lane-to-lane alignment from the words alone, with no side channel.

The generator has two run modes. In burst mode it sends fixed-length bursts marked with start and end flags, and it leaves one idle cycle between bursts. In continuous mode it streams without flags or gaps, and the burst number stays at 1. Traffic flows only while the enable input is high, and the downstream ready input throttles it. The active-low core reset holds the whole block in its initial state.

Top module: `lane_pattern_gen`

## Requirements
- R1: Lane i's 64-bit slice of `data` (bits i*64+63 down to i*64) carries i in bits 63:59, the burst number in bits 58:32 and the word number in bits 31:0. All lanes of a transfer show the same burst and word numbers.
- R2: While `rst_n` is low, `valid` is low, the burst number is 1, the word number is 1 and the mode is burst. An `enable` that is high during reset has no effect until reset is released.
- R3: When the block is idle and `enable` is sampled high, `valid` is high one cycle later.
- R4: Each accepted transfer (`valid` and `ready` both high) raises the word number by exactly one. The word number is never cleared at a burst boundary.
- R5: While `valid` is high and `ready` is low, `valid`, `sob`, `eob` and `data` hold their values.
- R6: In burst mode a burst is BURST_LEN transfers. `sob` marks the first transfer and `eob` the last.
- R7: After a transfer with `eob` is accepted, `valid` is low for exactly one cycle if `enable` stays high, and the burst number of the next burst is one higher.
- R8: In continuous mode `sob` and `eob` stay low, no idle cycles are inserted, and the burst number is 1.
- R9: When `enable` goes low, a pending transfer is still completed. After it, `valid` stays low.
- R10: `burst_mode` (1 = burst, 0 = continuous) is sampled only while the block is idle and `enable` is low. If the sampled mode differs from the current mode, the burst number restarts at 1 at the first beat. At any other time `burst_mode` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low core reset, asynchronous |
| enable | input | 1 | Allows new traffic when high |
| burst_mode | input | 1 | 1 = burst mode, 0 = continuous mode |
| ready | input | 1 | Downstream can accept a transfer |
| valid | output | 1 | A transfer is offered |
| sob | output | 1 | First transfer of a burst |
| eob | output | 1 | Last transfer of a burst |
| data | output | LANES*64 | One sample word per lane |

## Verification
A wrong burst-position counter shows up at the ports within one burst. The `sob` or `eob` flag lands on the wrong beat, or the idle gap goes missing. A corrupted word or burst counter shows up on the very next offered transfer, because each field is compared against its expected value on every lane. A stall that lets state advance changes `data` while `ready` is low, so it is caught in the same cycle. A mode latched at the wrong time shows up as flags appearing, or going missing, on the next transfer after enable.

// File: rtl/lane_pattern_gen.sv
module lane_pattern_gen #(
  parameter int LANES     = 4,
  parameter int BURST_LEN = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic                  burst_mode,
  input  logic                  ready,
  output logic                  valid,
  output logic                  sob,
  output logic                  eob,
  output logic [LANES*64-1:0]   data
);
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  if (LANES < 1 || LANES > 32) begin : g_lane_range
    $error("LANES must be between 1 and 32");
  end

  logic              mode_q;
  logic [BEAT_W-1:0] beat_q;
  logic [26:0]       burst_q;
  logic [31:0]       word_q;

  wire accept   = valid && ready;
  wire last     = mode_q && (beat_q == LAST_BEAT);
  wire idle_off = !valid && !enable;

  assign sob = valid && mode_q && (beat_q == '0);
  assign eob = valid && last;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign data[g*64 +: 64] = {5'(g), burst_q, word_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      mode_q  <= 1'b1;
      beat_q  <= '0;
      burst_q <= 27'd1;
      word_q  <= 32'd1;
    end else begin
      if (accept) begin
        word_q <= word_q + 32'd1;
        valid  <= enable && !last;
        if (mode_q) begin
          if (last) begin
            beat_q  <= '0;
            burst_q <= burst_q + 27'd1;
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
      end else if (!valid) begin
        valid <= enable;
      end
      if (idle_off) begin
        mode_q <= burst_mode;
        if (burst_mode != mode_q) begin
          beat_q  <= '0;
          burst_q <= 27'd1;
        end
      end
    end
  end

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(data) && $stable(sob) && $stable(eob));

  // R4
  word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> word_q == $past(word_q) + 32'd1);

  // R7
  gap_after_eob_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eob && ready |=> !valid && burst_q == $past(burst_q) + 27'd1);

  // R8
  cont_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> burst_q == 27'd1 && !sob && !eob);

  // R9
  stop_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid && !enable |=> !valid);

  // R6
  flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sob || eob) |-> valid && mode_q);
endmodule

// File: tb/lane_pattern_gen_test.sv
module lane_pattern_gen_test;
  localparam int LANES = 3;
  localparam int BLEN  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic burst_mode = 1'b1;
  logic ready = 1'b0;
  logic valid, sob, eob;
  logic [LANES*64-1:0] data;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lane_pattern_gen #(.LANES(LANES), .BURST_LEN(BLEN)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .burst_mode(burst_mode),
    .ready(ready), .valid(valid), .sob(sob), .eob(eob), .data(data));

  // row: en, rdy, mode, exp valid, exp sob, exp eob, exp burst, exp word
  localparam logic [21:0] VEC [0:18] = '{
    {3'b111, 3'b110, 8'd1, 8'd1},  // R3 R6 start, sob
    {3'b111, 3'b100, 8'd1, 8'd2},  // R4
    {3'b101, 3'b100, 8'd1, 8'd2},  // R5 stall
    {3'b111, 3'b101, 8'd1, 8'd3},  // R6 eob
    {3'b111, 3'b000, 8'd2, 8'd4},  // R7 gap, burst+1
    {3'b111, 3'b110, 8'd2, 8'd4},  // R7 next burst sob
    {3'b101, 3'b110, 8'd2, 8'd4},  // R5 stall on sob
    {3'b011, 3'b000, 8'd2, 8'd5},  // R9 disable completes
    {3'b010, 3'b000, 8'd1, 8'd5},  // R10 switch to continuous
    {3'b110, 3'b100, 8'd1, 8'd5},  // R8 no flags
    {3'b111, 3'b100, 8'd1, 8'd6},  // R10 mode ignored while enabled
    {3'b111, 3'b100, 8'd1, 8'd7},  // R8
    {3'b111, 3'b100, 8'd1, 8'd8},  // R8 no gaps
    {3'b011, 3'b000, 8'd1, 8'd9},  // R9
    {3'b011, 3'b000, 8'd1, 8'd9},  // R10 back to burst
    {3'b111, 3'b110, 8'd1, 8'd9},  // R6
    {3'b111, 3'b100, 8'd1, 8'd10}, // R4
    {3'b111, 3'b101, 8'd1, 8'd11}, // R6
    {3'b111, 3'b000, 8'd2, 8'd12}  // R7
  };

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_lanes(input string req, input int bc, input int wc);
    for (int i = 0; i < LANES; i++) begin
      check({req, " R1 lane id"}, data[i*64+59 +: 5], i);
      check({req, " R1 burst"}, data[i*64+32 +: 27], bc);
      check({req, " R1 word"}, data[i*64 +: 32], wc);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R2: enable during reset is ignored
    enable = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 valid in reset", valid, 0);
    check_lanes("R2 reset", 1, 1);
    enable = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int r = 0; r < 19; r++) begin
      {enable, ready, burst_mode} = VEC[r][21:19];
      @(negedge clk);
      check($sformatf("row %0d R3 R7 R9 valid", r), valid, VEC[r][18]);
      check($sformatf("row %0d R6 R8 sob", r), sob, VEC[r][17]);
      check($sformatf("row %0d R6 R8 eob", r), eob, VEC[r][16]);
      check_lanes($sformatf("row %0d R4", r), VEC[r][15:8], VEC[r][7:0]);
    end
    // R2: reset mid-run restores counters and burst mode
    rst_n = 1'b0;
    @(negedge clk);
    check("R2 valid after reset", valid, 0);
    check_lanes("R2 mid reset", 1, 1);
    burst_mode = 1'b0;
    enable = 1'b1;
    ready = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 R3 valid", valid, 1);
    check("R2 R10 default burst sob", sob, 1);
    check_lanes("R2 first word", 1, 1);
    @(negedge clk);
    check("R5 held sob", sob, 1);
    check("R5 held valid", valid, 1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule